// File: doc/BRIEF.md
# ADC Acquisition Trigger Controller

This block sits between a sampling ADC and a host register bus on a multi-channel acquisition card. Conversions arrive as a valid strobe with a 16-bit two's complement word. The block decides when those words are kept, stores them in a sample FIFO, and lets the host read them back one word per access. Capture starts in one of three ways: a software start write, a rising edge on an external trigger pin, or either of these followed by a fixed settling wait of 72 sample periods. That wait is used after the sample clock has changed.

The host works through a small word-addressed register space. It writes a trigger setup word, a start strobe, a FIFO flush strobe and a terminal-count clear strobe. One address has two roles: reading it returns a status word, and writing it loads a control word. That control word sets DMA enable, demand-mode DMA and the interrupt sources, and it is also driven out whole to the card's routing logic. The block raises a DMA request toward the host DMA controller and latches a terminal-count flag from that controller. It has one interrupt output, formed from the sources the control word enables.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset the FIFO is empty, the overflow, end-of-acquisition and terminal-count flags are clear, the trigger logic is idle, and dmaReq and irq are low.
- R2: A write of any value to address 2 empties the FIFO, clears the overflow and end-of-acquisition flags, and returns the trigger logic to idle. While idle, start writes and samples have no effect.
- R3: Trigger word bits 1:0 hold the mode. A mode other than 3 (2 is the normal post-trigger code) starts capture on the trigger. A write of any value to address 1 is the software start. After the start, every sample strobe stores its 16-bit word unchanged. Reads of address 3 return the stored words in arrival order, one per read.
- R4: With mode 3, the first 72 sample strobes after the trigger are discarded and later strobes are stored.
- R5: When trigger word bit 4 is set, capture starts on a rising edge of extTrig, and software start writes are ignored.
- R6: Samples that arrive before the trigger fires, after a trigger word write at address 0 has armed the logic, are not stored.
- R7: A sample that arrives while the FIFO is full is discarded. It sets the sticky overflow flag (status bit 3) and the end-of-acquisition flag (status bit 4), and capture stops. Both flags clear only on a FIFO flush.
- R8: A read of address 5 returns bit 0 FIFO not empty, bit 3 overflow, bit 4 end of acquisition, bit 5 the calBusy input, bit 6 irq, bit 7 terminal-count flag, bits 9:8 the boardId input, and zero in every other bit.
- R9: When control bit 3 (DMA enable) and bit 12 (demand mode) are both set, dmaReq stays high for as long as the FIFO is not empty.
- R10: When DMA is enabled without demand mode, dmaReq pulses high for one cycle, and it pulses again only after a FIFO data read while words remain.
- R11: A high dmaTc input sets the terminal-count flag. A write of any value to address 4 clears it.
- R12: irq is high when control bit 11 is set and the terminal-count flag is set, or when control bit 8 is set and the FIFO is not empty. With bit 9 also set, this second source needs the FIFO at least half full instead of not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (pops the FIFO at address 3) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed register, combinational |
| sampleValid | input | 1 | Conversion strobe from the converter |
| sampleData | input | 16 | Conversion word, two's complement |
| extTrig | input | 1 | External start trigger, acts on its rising edge |
| calBusy | input | 1 | Offset calibration in progress |
| boardId | input | 2 | Board identifier |
| dmaTc | input | 1 | Terminal count from the host DMA controller |
| dmaReq | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |
| irqDmaCfg | output | 16 | Stored control word, routed to the card |

## Verification
Sample streams are fed before the trigger, after a software start in post mode, through the 72-strobe settling window, and under the external trigger with a stray software start. These separate the three start paths and show that early samples are dropped. Capture is also run past full depth, so a discarded extra word can be told apart from a stored one. Each stream goes through a scoreboard queue, which catches reordering, corrupted words and off-by-one settling counts. DMA is run in demand mode and in single-pulse mode, and the interrupt is run with each source enabled on its own, so each source can be told apart from the others.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SETTLE,
    ST_CAPTURE
  } acqState_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCmd_t;

  localparam logic [2:0] ADDR_TRIG   = 3'd0;
  localparam logic [2:0] ADDR_START  = 3'd1;
  localparam logic [2:0] ADDR_FLUSH  = 3'd2;
  localparam logic [2:0] ADDR_DATA   = 3'd3;
  localparam logic [2:0] ADDR_TCCLR  = 3'd4;
  localparam logic [2:0] ADDR_STATUS = 3'd5;

  localparam int CTL_DMA_EN   = 3;
  localparam int CTL_FIFO_IE  = 8;
  localparam int CTL_HALF_SEL = 9;
  localparam int CTL_TC_IE    = 11;
  localparam int CTL_DEMAND   = 12;

  localparam logic [1:0] MODE_DELAY = 2'd3;
  localparam int TRIG_HW_BIT = 4;
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo
  import acq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              notEmpty,
  output logic              full,
  output logic              halfFull,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  assign notEmpty = (count != '0);
  assign full     = (count == CW'(DEPTH));
  assign halfFull = (count >= CW'(DEPTH / 2));
  assign doPush   = cmd.push && !full;
  assign doPop    = cmd.pop && notEmpty;
  assign rdData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !cmd.flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
      if (cmd.push && full) overflow <= 1'b1;
    end
  end

  // R2: a flush leaves the FIFO empty with no overflow
  p_flush_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> (!notEmpty && !overflow));
  // R7: overflow is sticky until a flush
  p_ovfl_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !cmd.flush) |=> overflow);
  // R7: occupancy never exceeds the depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int SETTLE_LEN = 72,
  parameter int BUS_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  input  logic             sampleValid,
  input  logic             extTrig,
  input  logic             dmaTc,
  input  logic             fifoNotEmpty,
  input  logic             fifoFull,
  input  logic             fifoHalf,
  output fifoCmd_t         cmd,
  output logic             eoaFlag,
  output logic             tcFlag,
  output logic             irq,
  output logic             dmaReq,
  output logic [BUS_W-1:0] ctlWord
);
  localparam int SCW = $clog2(SETTLE_LEN + 1);

  acqState_t state;
  logic [SCW-1:0] settleCnt;
  logic [1:0] trigMode;
  logic hwEn, extPrev, waitPop;
  logic trigWr, startWr, flushWr, tcClrWr, ctlWr, extRise, trigNow;

  assign trigWr  = busWr && busAddr == ADDR_TRIG;
  assign startWr = busWr && busAddr == ADDR_START;
  assign flushWr = busWr && busAddr == ADDR_FLUSH;
  assign tcClrWr = busWr && busAddr == ADDR_TCCLR;
  assign ctlWr   = busWr && busAddr == ADDR_STATUS;
  assign extRise = extTrig && !extPrev;
  assign trigNow = (state == ST_ARMED) && (hwEn ? extRise : startWr);

  assign cmd.push  = (state == ST_CAPTURE) && sampleValid;
  assign cmd.pop   = busRd && busAddr == ADDR_DATA;
  assign cmd.flush = flushWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      trigMode  <= '0;
      hwEn      <= 1'b0;
      extPrev   <= 1'b0;
      eoaFlag   <= 1'b0;
    end else begin
      extPrev <= extTrig;
      if (flushWr) begin
        state   <= ST_IDLE;
        eoaFlag <= 1'b0;
      end else if (trigWr) begin
        trigMode <= busWdata[1:0];
        hwEn     <= busWdata[TRIG_HW_BIT];
        state    <= ST_ARMED;
      end else begin
        unique case (state)
          ST_ARMED: if (trigNow) begin
            settleCnt <= '0;
            state <= (trigMode == MODE_DELAY) ? ST_SETTLE : ST_CAPTURE;
          end
          ST_SETTLE: if (sampleValid) begin
            if (settleCnt == SCW'(SETTLE_LEN - 1)) state <= ST_CAPTURE;
            else settleCnt <= settleCnt + 1'b1;
          end
          ST_CAPTURE: if (sampleValid && fifoFull) begin
            state   <= ST_IDLE;
            eoaFlag <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlWord <= '0;
      tcFlag  <= 1'b0;
      waitPop <= 1'b0;
    end else begin
      if (ctlWr) ctlWord <= busWdata;
      if (dmaTc) tcFlag <= 1'b1;
      else if (tcClrWr) tcFlag <= 1'b0;
      if (dmaReq) waitPop <= 1'b1;
      else if (cmd.pop) waitPop <= 1'b0;
    end
  end

  assign dmaReq = ctlWord[CTL_DMA_EN] && fifoNotEmpty &&
                  (ctlWord[CTL_DEMAND] || !waitPop);
  assign irq = (ctlWord[CTL_TC_IE] && tcFlag) ||
               (ctlWord[CTL_FIFO_IE] &&
                (ctlWord[CTL_HALF_SEL] ? fifoHalf : fifoNotEmpty));

  // R2: a flush write returns the trigger logic to idle
  p_flush_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    flushWr |=> state == ST_IDLE);
  // R5: armed with the hardware trigger, only an edge leaves the armed state
  p_hw_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && hwEn && !extRise && !trigWr && !flushWr) |=> state == ST_ARMED);
  // R9: a request needs DMA enabled and data present
  p_req_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (ctlWord[CTL_DMA_EN] && fifoNotEmpty));
  // R10: without demand mode a request lasts one cycle
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !ctlWord[CTL_DEMAND] && !ctlWr) |=> !dmaReq);
  // R11: the terminal-count flag only rises after a terminal count
  p_tc_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcFlag) |-> $past(dmaTc));
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int SETTLE_LEN = 72
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  input  logic        sampleValid,
  input  logic [15:0] sampleData,
  input  logic        extTrig,
  input  logic        calBusy,
  input  logic [1:0]  boardId,
  input  logic        dmaTc,
  output logic        dmaReq,
  output logic        irq,
  output logic [15:0] irqDmaCfg
);
  fifoCmd_t cmd;
  logic [15:0] fifoData;
  logic notEmpty, full, halfFull, overflow, eoaFlag, tcFlag;
  logic [15:0] statusWord;

  acq_ctrl #(.SETTLE_LEN(SETTLE_LEN), .BUS_W(16)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .sampleValid(sampleValid), .extTrig(extTrig),
    .dmaTc(dmaTc), .fifoNotEmpty(notEmpty), .fifoFull(full), .fifoHalf(halfFull),
    .cmd(cmd), .eoaFlag(eoaFlag), .tcFlag(tcFlag), .irq(irq), .dmaReq(dmaReq),
    .ctlWord(irqDmaCfg)
  );

  acq_fifo #(.DATA_W(16), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(sampleData), .rdData(fifoData),
    .notEmpty(notEmpty), .full(full), .halfFull(halfFull), .overflow(overflow)
  );

  assign statusWord = {6'b0, boardId, tcFlag, irq, calBusy, eoaFlag,
                       overflow, 2'b0, notEmpty};

  always_comb begin
    unique case (busAddr)
      ADDR_STATUS: busRdata = statusWord;
      ADDR_DATA:   busRdata = fifoData;
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: tb/sim_acq_trig_ctrl.sv
module sim_acq_trig_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rstN = 0;
  logic [2:0] busAddr = 0;
  logic busWr = 0, busRd = 0;
  logic [15:0] busWdata = 0;
  logic [15:0] busRdata;
  logic sampleValid = 0;
  logic [15:0] sampleData = 0;
  logic extTrig = 0, calBusy = 0, dmaTc = 0;
  logic [1:0] boardId = 2'b10;
  logic dmaReq, irq;
  logic [15:0] irqDmaCfg;

  int nTests = 0, nFails = 0;
  logic [15:0] expQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_trig_ctrl #(.DEPTH(DEPTH), .SETTLE_LEN(72)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sampleValid(sampleValid),
    .sampleData(sampleData), .extTrig(extTrig), .calBusy(calBusy),
    .boardId(boardId), .dmaTc(dmaTc), .dmaReq(dmaReq), .irq(irq),
    .irqDmaCfg(irqDmaCfg)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [15:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk); busWr = 0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); busAddr = a; busRd = 1; #1 d = busRdata;
    @(negedge clk); busRd = 0;
  endtask

  // driver: one sample strobe, expected result pushed to the scoreboard
  task automatic drive(logic [15:0] d, bit kept);
    @(negedge clk); sampleValid = 1; sampleData = d;
    if (kept) expQ.push_back(d);
    @(negedge clk); sampleValid = 0;
  endtask

  // monitor: pop the FIFO and compare against the scoreboard
  task automatic drain(string tag);
    logic [15:0] st, d;
    while (expQ.size() > 0) begin
      busRead(3'd5, st);
      check({tag, " not-empty"}, st[0], 1'b1);
      busRead(3'd3, d);
      check({tag, " data"}, d, expQ.pop_front());
    end
    busRead(3'd5, st);
    check({tag, " empty after drain"}, st[0], 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] st;
    int hi;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    busRead(3'd5, st);
    check("R1 status", st, 16'h0200);
    check("R1 dmaReq", dmaReq, 0);
    check("R1 irq", irq, 0);
    // R8 calibration input
    calBusy = 1; busRead(3'd5, st);
    check("R8 cal bit", st, 16'h0220);
    calBusy = 0;
    // R6 samples before trigger; R3 post trigger
    busWrite(3'd0, 16'h0002);
    drive(16'h1111, 0); drive(16'h2222, 0);
    busRead(3'd5, st); check("R6 pre-trigger empty", st[0], 0);
    busWrite(3'd1, 16'h0000);
    drive(16'h8000, 1); drive(16'h7fff, 1); drive(16'h1234, 1);
    drain("R3");
    // R4 delayed mode
    busWrite(3'd2, 0);
    busWrite(3'd0, 16'h0003);
    busWrite(3'd1, 0);
    for (int i = 0; i < 72; i++) drive(16'(i + 1), 0);
    busRead(3'd5, st); check("R4 settle discards", st[0], 0);
    drive(16'haaaa, 1); drive(16'h5555, 1);
    drain("R4");
    // R5 external trigger, software start ignored
    busWrite(3'd2, 0);
    busWrite(3'd0, 16'h0012);
    busWrite(3'd1, 0);
    drive(16'hdead, 0);
    busRead(3'd5, st); check("R5 sw start ignored", st[0], 0);
    @(negedge clk); extTrig = 1; @(negedge clk); extTrig = 0;
    drive(16'hbeef, 1);
    drain("R5");
    // R7 overflow
    busWrite(3'd2, 0);
    busWrite(3'd0, 16'h0002);
    busWrite(3'd1, 0);
    for (int i = 0; i < DEPTH; i++) drive(16'(16'h0100 + i), 1);
    drive(16'hffff, 0);
    busRead(3'd5, st);
    check("R7 ovfl+eoa", st[4:3], 2'b11);
    drive(16'heeee, 0);
    drain("R7");
    busRead(3'd5, st); check("R7 sticky", st[4:3], 2'b11);
    // R2 flush
    busWrite(3'd2, 16'h5a5a);
    busRead(3'd5, st); check("R2 flags cleared", st, 16'h0200);
    busWrite(3'd1, 0);
    drive(16'h4321, 0);
    busRead(3'd5, st); check("R2 idle ignores start", st[0], 0);
    // R9 demand DMA
    busWrite(3'd5, 16'h1008);
    busWrite(3'd0, 16'h0002);
    busWrite(3'd1, 0);
    drive(16'h0a0a, 1); drive(16'h0b0b, 1);
    hi = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); #1 hi += int'(dmaReq); end
    check("R9 held high", hi, 4);
    busRead(3'd3, st); check("R9 data", st, expQ.pop_front());
    #1 check("R9 still high", dmaReq, 1);
    busRead(3'd3, st); check("R9 data", st, expQ.pop_front());
    #1 check("R9 low when empty", dmaReq, 0);
    // R10 single pulse DMA
    busWrite(3'd5, 16'h0008);
    drive(16'h0c0c, 1);
    hi = 0;
    drive(16'h0d0d, 1);
    for (int i = 0; i < 5; i++) begin @(negedge clk); #1 hi += int'(dmaReq); end
    check("R10 no repeat before read", hi, 0);
    busRead(3'd3, st); check("R10 data", st, expQ.pop_front());
    hi = 0;
    for (int i = 0; i < 5; i++) begin #1 hi += int'(dmaReq); @(negedge clk); end
    check("R10 one pulse after read", hi, 1);
    drain("R10");
    // R11 terminal count / R12 irq from tc
    busWrite(3'd5, 16'h0800);
    @(negedge clk); dmaTc = 1; @(negedge clk); dmaTc = 0;
    busRead(3'd5, st);
    check("R11 tc flag", st[7], 1);
    check("R12 irq mirror", st[6], 1);
    check("R12 irq tc", irq, 1);
    busWrite(3'd4, 16'h1234);
    busRead(3'd5, st);
    check("R11 tc cleared", st[7], 0);
    check("R12 irq low", irq, 0);
    // R12 fifo sources
    busWrite(3'd5, 16'h0100);
    drive(16'h0001, 1);
    #1 check("R12 not-empty irq", irq, 1);
    busWrite(3'd5, 16'h0300);
    #1 check("R12 half below", irq, 0);
    for (int i = 1; i < DEPTH/2; i++) drive(16'(i + 1), 1);
    #1 check("R12 half reached", irq, 1);
    busWrite(3'd5, 16'h0000);
    drain("R12");
    check("R12 cfg out", irqDmaCfg, 16'h0000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule